// File: doc/BRIEF.md
# Memory-Fed Full-Duplex SPI Master

This block is a serial-peripheral master that moves bytes between a byte-wide local memory port and the SPI wires with no processor in the loop. Software sets a transmit base address and byte count, a receive base address and byte count, and a fill byte. It then pulses a start request. The engine reads each outgoing byte from memory, shifts it out on MOSI and shifts in a byte from MISO at the same time, then writes the incoming byte back to memory. Bits go most-significant first.

The two counts are independent. The transaction runs for the larger of the two. Outgoing bytes past the transmit count are replaced by the fill byte. Incoming bytes past the receive count are thrown away. Progress is reported through single-cycle event pulses: started, transmit side done, receive side done, end and stopped. The base, count and fill inputs are sampled once, when a start is accepted. Software may therefore load the next transaction's values as soon as the started pulse appears.

A stop request ends the transaction at the next byte boundary. Chip select is driven outside the block. The memory port has one address shared by reads and writes, and a read latency of one cycle. SCK runs at the system clock divided by 2×DIV.

Top module: `spi_dma_master`

## Requirements
- R1: SCK rests at the level of `cpol` whenever no byte is shifting. Each byte makes exactly 16 SCK toggles, with each half period lasting DIV clock cycles. With `cpha`=0, MISO is captured on the first edge of each bit and MOSI changes on the second edge. With `cpha`=1, MOSI changes on the first edge and MISO is captured on the second edge.
- R2: Each byte shifted out on MOSI is paired with exactly one byte shifted in from MISO, most-significant bit first. The number of bytes shifted equals the larger of `txLen` and `rxLen`.
- R3: Outgoing byte i, for i < `txLen`, is the memory byte at address `txBase`+i. Each outgoing byte at i ≥ `txLen` equals `fillByte`.
- R4: Incoming byte i is written to `rxBase`+i only when i < `rxLen`. Later incoming bytes cause no memory write.
- R5: Memory reads happen only for transmit bytes, exactly `txLen` of them in ascending address order. Memory writes happen only for receive bytes, exactly `rxLen` of them when the transaction is not stopped.
- R6: `evTxDone` pulses when the last transmit byte is taken from memory. `evRxDone` pulses when the last receive byte is written. A side with a count of zero pulses its event in the cycle right after `evStarted`.
- R7: `evEnd` pulses once, in a later cycle than both `evTxDone` and `evRxDone` of the same transaction. `evEnd` does not pulse for a stopped transaction.
- R8: A stop request during a transaction lets the byte in flight finish, including its memory write. The engine then pulses `evStopped`. In that same cycle it pulses whichever of `evTxDone` and `evRxDone` has not fired yet. SCK is at its rest level when `evStopped` pulses.
- R9: A start request while a transaction is in progress is ignored: it causes no second `evStarted` and does not change the running transaction.
- R10: `txBase`, `txLen`, `rxBase`, `rxLen` and `fillByte` are sampled only in the cycle a start is accepted. Later changes do not affect the running transaction.
- R11: Every event is a single-cycle pulse. `evStarted` rises in the cycle after the accepted `startReq`.
- R12: A stop request while idle has no effect: no event pulses and no memory access happens.
- R13: `memRe` and `memWe` are never high in the same cycle. Read data is taken one cycle after `memRe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK rest level; hold stable during a transaction |
| cpha | input | 1 | 0: capture on first edge, 1: capture on second edge |
| txBase | input | ADDR_W | Base address of the outgoing bytes |
| txLen | input | CNT_W | Number of outgoing bytes read from memory |
| rxBase | input | ADDR_W | Base address for the incoming bytes |
| rxLen | input | CNT_W | Number of incoming bytes written to memory |
| fillByte | input | 8 | Byte sent once the transmit count is used up |
| startReq | input | 1 | One-cycle start request |
| stopReq | input | 1 | One-cycle stop request |
| memAddr | output | ADDR_W | Memory address shared by reads and writes |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write data |
| memRdata | input | 8 | Memory read data, valid one cycle after memRe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| evStarted | output | 1 | Transaction accepted, inputs sampled |
| evTxDone | output | 1 | Transmit side finished or forced |
| evRxDone | output | 1 | Receive side finished or forced |
| evEnd | output | 1 | Transaction complete |
| evStopped | output | 1 | Transaction ended by a stop request |

## Verification
The collision of interest is a stop request arriving during the last byte, so that natural completion and stop handling meet in the same decision cycle. The bench sends a one-byte transaction and raises the stop request in the middle of that byte's shifting. The correct outcome is `evStopped` with no `evEnd`. Each of `evTxDone` and `evRxDone` must pulse exactly once, never a second forced copy, and the single received byte must still land in memory. A start request that coincides with a running transaction is provoked the same way, and is judged by the event counts and by the bytes seen on the wire.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_FETCH, ST_LOAD, ST_SHIFT, ST_STORE, ST_DONE
  } engState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic fetch;
    logic load;
    logic run;
    logic store;
  } engStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic txZero;
    logic rxZero;
    logic lenZero;
    logic txMore;
    logic txLast;
    logic rxMore;
    logic rxLast;
    logic lastByte;
    logic shiftDone;
  } engStatus_t;

endpackage

// File: rtl/spi_dma_datapath.sv
module spi_dma_datapath
  import spi_dma_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8,
  parameter int DIV    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        stb,
  output engStatus_t        sts,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [ADDR_W-1:0] txBase,
  input  logic [CNT_W-1:0]  txLen,
  input  logic [ADDR_W-1:0] rxBase,
  input  logic [CNT_W-1:0]  rxLen,
  input  logic [7:0]        fillByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam int HALF_W = 4;
  localparam logic [HALF_W-1:0] HALF_LAST = 4'd15;

  // shadow copies taken at start
  logic [ADDR_W-1:0] txBaseQ, rxBaseQ;
  logic [CNT_W-1:0]  txLenQ, rxLenQ, runLen;
  logic [7:0]        fillQ;

  logic [CNT_W-1:0]  txIdx, rxIdx, byteIdx;
  logic [7:0]        txShift, rxShift;
  logic [DIV_W-1:0]  divCnt;
  logic [HALF_W-1:0] half;
  logic              phase;

  logic edgeNow, leadEdge, sampleEdge, driveEdge;

  always_comb begin
    runLen     = (txLenQ > rxLenQ) ? txLenQ : rxLenQ;
    edgeNow    = stb.run && (divCnt == DIV_LAST);
    leadEdge   = ~half[0];
    sampleEdge = edgeNow && (cpha ? !leadEdge : leadEdge);
    driveEdge  = edgeNow && (cpha ? (leadEdge && (half != '0)) : !leadEdge);
  end

  always_comb begin
    sts.txZero    = (txLenQ == '0);
    sts.rxZero    = (rxLenQ == '0);
    sts.lenZero   = (runLen == '0);
    sts.txMore    = (txIdx < txLenQ);
    sts.txLast    = (txIdx == txLenQ - CNT_W'(1));
    sts.rxMore    = (rxIdx < rxLenQ);
    sts.rxLast    = (rxIdx == rxLenQ - CNT_W'(1));
    sts.lastByte  = (byteIdx == runLen - CNT_W'(1));
    sts.shiftDone = edgeNow && (half == HALF_LAST);
  end

  always_comb begin
    memRe    = stb.fetch && sts.txMore;
    memWe    = stb.store && sts.rxMore;
    memAddr  = stb.store ? (rxBaseQ + ADDR_W'(rxIdx)) : (txBaseQ + ADDR_W'(txIdx));
    memWdata = rxShift;
    sck      = cpol ^ phase;
    mosi     = txShift[7];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBaseQ <= '0;
      rxBaseQ <= '0;
      txLenQ  <= '0;
      rxLenQ  <= '0;
      fillQ   <= '0;
      txIdx   <= '0;
      rxIdx   <= '0;
      byteIdx <= '0;
      txShift <= '0;
      rxShift <= '0;
      divCnt  <= '0;
      half    <= '0;
      phase   <= 1'b0;
    end else begin
      if (stb.capture) begin
        txBaseQ <= txBase;
        rxBaseQ <= rxBase;
        txLenQ  <= txLen;
        rxLenQ  <= rxLen;
        fillQ   <= fillByte;
        txIdx   <= '0;
        rxIdx   <= '0;
        byteIdx <= '0;
      end
      if (stb.load) begin
        txShift <= sts.txMore ? memRdata : fillQ;
        if (sts.txMore) txIdx <= txIdx + CNT_W'(1);
        divCnt <= '0;
        half   <= '0;
      end
      if (stb.run) begin
        divCnt <= edgeNow ? '0 : divCnt + DIV_W'(1);
        if (edgeNow) begin
          phase <= ~phase;
          half  <= half + HALF_W'(1);
        end
        if (sampleEdge) rxShift <= {rxShift[6:0], miso};
        if (driveEdge)  txShift <= {txShift[6:0], 1'b0};
      end
      if (stb.store) begin
        if (sts.rxMore) rxIdx <= rxIdx + CNT_W'(1);
        byteIdx <= byteIdx + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/spi_dma_ctrl.sv
module spi_dma_ctrl
  import spi_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       stopReq,
  input  engStatus_t sts,
  output engStrobe_t stb,
  output logic       evStarted,
  output logic       evTxDone,
  output logic       evRxDone,
  output logic       evEnd,
  output logic       evStopped
);

  engState_e state, nextState;
  logic stopPend, stopNow, txFired, rxFired;
  logic setTx, setRx;

  always_comb stopNow = stopPend || stopReq;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stb.capture = 1'b1;
        nextState   = ST_ARM;
      end
      ST_ARM:   nextState = (sts.lenZero || stopNow) ? ST_DONE : ST_FETCH;
      ST_FETCH: begin
        stb.fetch = 1'b1;
        nextState = ST_LOAD;
      end
      ST_LOAD: begin
        stb.load  = 1'b1;
        nextState = ST_SHIFT;
      end
      ST_SHIFT: begin
        stb.run = 1'b1;
        if (sts.shiftDone) nextState = ST_STORE;
      end
      ST_STORE: begin
        stb.store = 1'b1;
        nextState = (sts.lastByte || stopNow) ? ST_DONE : ST_FETCH;
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    setTx = ((state == ST_ARM) && sts.txZero)
         || ((state == ST_LOAD) && sts.txMore && sts.txLast)
         || ((state == ST_DONE) && stopNow && !txFired);
    setRx = ((state == ST_ARM) && sts.rxZero)
         || ((state == ST_STORE) && sts.rxMore && sts.rxLast)
         || ((state == ST_DONE) && stopNow && !rxFired);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stopPend  <= 1'b0;
      txFired   <= 1'b0;
      rxFired   <= 1'b0;
      evStarted <= 1'b0;
      evTxDone  <= 1'b0;
      evRxDone  <= 1'b0;
      evEnd     <= 1'b0;
      evStopped <= 1'b0;
    end else begin
      state <= nextState;
      if ((state == ST_IDLE) || (state == ST_DONE)) stopPend <= 1'b0;
      else if (stopReq)                             stopPend <= 1'b1;
      if (stb.capture) begin
        txFired <= 1'b0;
        rxFired <= 1'b0;
      end else begin
        if (setTx) txFired <= 1'b1;
        if (setRx) rxFired <= 1'b1;
      end
      evStarted <= stb.capture;
      evTxDone  <= setTx;
      evRxDone  <= setRx;
      evEnd     <= (state == ST_DONE) && !stopNow;
      evStopped <= (state == ST_DONE) && stopNow;
    end
  end

endmodule

// File: rtl/spi_dma_master.sv
module spi_dma_master
  import spi_dma_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 8,
  parameter int DIV    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [ADDR_W-1:0] txBase,
  input  logic [CNT_W-1:0]  txLen,
  input  logic [ADDR_W-1:0] rxBase,
  input  logic [CNT_W-1:0]  rxLen,
  input  logic [7:0]        fillByte,
  input  logic              startReq,
  input  logic              stopReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              evStarted,
  output logic              evTxDone,
  output logic              evRxDone,
  output logic              evEnd,
  output logic              evStopped
);

  engStrobe_t stb;
  engStatus_t sts;

  spi_dma_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .stopReq   (stopReq),
    .sts       (sts),
    .stb       (stb),
    .evStarted (evStarted),
    .evTxDone  (evTxDone),
    .evRxDone  (evRxDone),
    .evEnd     (evEnd),
    .evStopped (evStopped)
  );

  spi_dma_datapath #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DIV    (DIV)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .sts      (sts),
    .cpol     (cpol),
    .cpha     (cpha),
    .txBase   (txBase),
    .txLen    (txLen),
    .rxBase   (rxBase),
    .rxLen    (rxLen),
    .fillByte (fillByte),
    .memAddr  (memAddr),
    .memRe    (memRe),
    .memWe    (memWe),
    .memWdata (memWdata),
    .memRdata (memRdata),
    .sck      (sck),
    .mosi     (mosi),
    .miso     (miso)
  );

endmodule

// File: rtl/spi_dma_checker.sv
module spi_dma_checker (
  input logic clk,
  input logic rstN,
  input logic cpol,
  input logic sck,
  input logic memRe,
  input logic memWe,
  input logic evStarted,
  input logic evTxDone,
  input logic evRxDone,
  input logic evEnd,
  input logic evStopped
);

  logic busyC, txSeen, rxSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyC  <= 1'b0;
      txSeen <= 1'b0;
      rxSeen <= 1'b0;
    end else begin
      if (evStarted)              busyC <= 1'b1;
      else if (evEnd || evStopped) busyC <= 1'b0;
      txSeen <= evStarted ? 1'b0 : (txSeen || evTxDone);
      rxSeen <= evStarted ? 1'b0 : (rxSeen || evRxDone);
    end
  end

  AST_SCK_REST_AT_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (evStarted || evEnd || evStopped) |-> (sck == cpol)); // R1

  AST_END_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    evEnd |-> (txSeen && rxSeen)); // R7

  AST_STOP_FORCES_DONE: assert property (@(posedge clk) disable iff (!rstN)
    evStopped |-> ((txSeen || evTxDone) && (rxSeen || evRxDone))); // R8

  AST_NO_NESTED_START: assert property (@(posedge clk) disable iff (!rstN)
    evStarted |-> !busyC); // R9

  AST_STARTED_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    evStarted |=> !evStarted); // R11

  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    evEnd |=> !evEnd); // R11

  AST_STOPPED_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    evStopped |=> !evStopped); // R11

  AST_MEM_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R13

endmodule

bind spi_dma_master spi_dma_checker u_chk (.*);

// File: tb/tb_spi_dma_master.sv
module tb_spi_dma_master;

  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic        cpol = 1'b0, cpha = 1'b0;
  logic [11:0] txBase = '0, rxBase = '0;
  logic [7:0]  txLen = '0, rxLen = '0, fillByte = '0;
  logic        startReq = 1'b0, stopReq = 1'b0;
  logic [11:0] memAddr;
  logic        memRe, memWe;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic        evStarted, evTxDone, evRxDone, evEnd, evStopped;

  spi_dma_master #(.ADDR_W(12), .CNT_W(8), .DIV(DIV)) dut (.*);

  // memory model, one-cycle read latency
  logic [7:0] mem [256];
  always @(posedge clk) begin
    if (memRe) memRdata <= mem[memAddr[7:0]];
    if (memWe) mem[memAddr[7:0]] <= memWdata;
  end

  // SPI slave model
  logic [7:0] sResp [17];
  logic [7:0] sGot  [16];
  logic [7:0] sTx, sRx;
  int sBit, sIdx;
  logic armed = 1'b0;
  logic lead;
  always @(posedge sck or negedge sck) begin
    if (rstN && armed) begin
      lead = (sck != cpol);
      if (cpha ? !lead : lead) begin
        sRx = {sRx[6:0], mosi};
        sBit++;
        if (sBit == 8) begin
          if (sIdx < 16) sGot[sIdx] = sRx;
          sIdx++;
          sBit = 0;
          if (!cpha) begin
            sTx = sResp[(sIdx < 16) ? sIdx : 16];
            miso = sTx[7];
          end
        end
      end else begin
        if (cpha) begin
          if (sBit == 0) sTx = sResp[(sIdx < 16) ? sIdx : 16];
          else           sTx = {sTx[6:0], 1'b0};
          miso = sTx[7];
        end else if (sBit != 0) begin
          sTx = {sTx[6:0], 1'b0};
          miso = sTx[7];
        end
      end
    end
  end

  // event monitor
  int cyc = 0;
  int nStart, nTx, nRx, nEnd, nStop, nRd, nWr, toggles;
  int cStart, cTx, cRx, cEnd, cTask;
  logic sckPrev = 1'b0, sckAtStop = 1'b0, bothSeen = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (startReq)  cTask = cyc;
      if (evStarted) begin nStart++; cStart = cyc; end
      if (evTxDone)  begin nTx++;    cTx = cyc;    end
      if (evRxDone)  begin nRx++;    cRx = cyc;    end
      if (evEnd)     begin nEnd++;   cEnd = cyc;   end
      if (evStopped) begin nStop++;  sckAtStop = sck; end
      if (memRe) nRd++;
      if (memWe) nWr++;
      if (memRe && memWe) bothSeen = 1'b1;
      if (sck !== sckPrev) toggles++;
    end
    sckPrev = sck;
  end

  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    nStart = 0; nTx = 0; nRx = 0; nEnd = 0; nStop = 0;
    nRd = 0; nWr = 0; toggles = 0;
    cStart = -1; cTx = -1; cRx = -1; cEnd = -1; cTask = -1;
  endtask

  task automatic prep(input logic pol, input logic pha, input int txp, input int txc,
                      input int rxp, input int rxc, input logic [7:0] fill, input int seed);
    @(posedge clk); #1;
    cpol = pol; cpha = pha;
    txBase = 12'(txp); txLen = 8'(txc); rxBase = 12'(rxp); rxLen = 8'(rxc);
    fillByte = fill;
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    for (int i = 0; i < 16; i++) mem[(txp + i) & 255] = 8'(8'h31 + i * 7 + seed);
    for (int i = 0; i < 17; i++) sResp[i] = 8'(8'hC5 ^ (i * 13 + seed));
    @(negedge clk); @(posedge clk); #1;
    sIdx = 0; sBit = 0; sRx = '0;
    sTx = sResp[0]; miso = sTx[7];
    armed = 1'b1;
    clear_counts();
  endtask

  task automatic go(input int stopAt);
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    if (stopAt > 0) begin
      repeat (stopAt) @(posedge clk);
      #1 stopReq = 1'b1;
      @(posedge clk); #1 stopReq = 1'b0;
    end
    while (nEnd + nStop == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    armed = 1'b0;
  endtask

  task automatic verify_data(input int txp, input int txc, input int rxp, input int rxc,
                             input logic [7:0] fill);
    int len;
    logic [7:0] expB;
    len = (txc > rxc) ? txc : rxc;
    check(sIdx == len, "R2 bytes on wire", sIdx, len);
    check(toggles == 16 * len, "R1 sck toggles", toggles, 16 * len);
    check(sck == cpol, "R1 sck rest level", sck, cpol);
    for (int i = 0; i < len; i++) begin
      expB = (i < txc) ? mem[(txp + i) & 255] : fill;
      check(sGot[i] == expB, "R3 outgoing byte", sGot[i], expB);
      if (i < rxc) check(mem[(rxp + i) & 255] == sResp[i], "R2 incoming byte stored",
                         mem[(rxp + i) & 255], sResp[i]);
      else         check(mem[(rxp + i) & 255] == 8'hEE, "R4 surplus byte dropped",
                         mem[(rxp + i) & 255], 8'hEE);
    end
    check(nRd == txc, "R5 read count", nRd, txc);
    check(nWr == rxc, "R5 write count", nWr, rxc);
    check(nStart == 1, "R11 one started pulse", nStart, 1);
    check(cStart == cTask + 1, "R11 started timing", cStart, cTask + 1);
    check(nTx == 1 && nRx == 1, "R6 done events once", nTx * 16 + nRx, 17);
    check(nEnd == 1 && nStop == 0, "R7 one end pulse", nEnd, 1);
    check(cEnd > cTx && cEnd > cRx, "R7 end after both", cEnd, cTx + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(sck == 1'b0, "R1 reset sck", sck, 0);
    check(!memRe && !memWe, "R13 reset memory idle", {memRe, memWe}, 0);
    check(!(evStarted | evTxDone | evRxDone | evEnd | evStopped), "R11 reset events", 1, 0);
  endtask

  task automatic t_mode(input logic pol, input logic pha, input int txc, input int rxc, input int seed);
    prep(pol, pha, 8'h10, txc, 8'h80, rxc, 8'h5A, seed);
    check(sck == pol, "R1 idle level follows cpol", sck, pol);
    go(0);
    verify_data(8'h10, txc, 8'h80, rxc, 8'h5A);
  endtask

  task automatic t_zero();
    prep(1'b0, 1'b0, 8'h10, 0, 8'h80, 0, 8'h00, 3);
    go(0);
    check(cTx == cStart + 1, "R6 zero tx event timing", cTx, cStart + 1);
    check(cRx == cStart + 1, "R6 zero rx event timing", cRx, cStart + 1);
    check(cEnd > cRx, "R7 end after zero-count events", cEnd, cRx + 1);
    check(toggles == 0 && nRd == 0 && nWr == 0, "R2 empty transfer idle", toggles + nRd + nWr, 0);
    prep(1'b0, 1'b0, 8'h10, 0, 8'h80, 2, 8'hA7, 4);
    go(0);
    check(cTx == cStart + 1, "R6 zero tx with rx", cTx, cStart + 1);
    verify_data(8'h10, 0, 8'h80, 2, 8'hA7);
  endtask

  task automatic t_stop_mid();
    prep(1'b1, 1'b1, 8'h10, 4, 8'h80, 4, 8'h00, 5);
    go(8);
    check(nStop == 1 && nEnd == 0, "R8 stopped without end", nStop, 1);
    check(sIdx == 1, "R8 byte in flight completed", sIdx, 1);
    check(mem[8'h80] == sResp[0], "R8 in-flight byte stored", mem[8'h80], sResp[0]);
    check(mem[8'h81] == 8'hEE, "R8 nothing after stop", mem[8'h81], 8'hEE);
    check(nTx == 1 && nRx == 1, "R8 forced done events", nTx * 16 + nRx, 17);
    check(cTx == cRx, "R8 forced events together", cTx, cRx);
    check(sckAtStop == cpol, "R8 sck at rest on stop", sckAtStop, cpol);
  endtask

  task automatic t_stop_last();
    prep(1'b0, 1'b0, 8'h10, 1, 8'h80, 1, 8'h00, 6);
    go(8);
    check(nStop == 1 && nEnd == 0, "R8 stop on last byte", nStop * 16 + nEnd, 16);
    check(nTx == 1 && nRx == 1, "R8 no duplicate done events", nTx * 16 + nRx, 17);
    check(mem[8'h80] == sResp[0], "R8 last byte stored", mem[8'h80], sResp[0]);
  endtask

  task automatic t_busy_start();
    prep(1'b0, 1'b1, 8'h10, 2, 8'h80, 2, 8'h3C, 7);
    @(posedge clk); #1 startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    repeat (10) @(posedge clk);
    #1 txBase = 12'h040; txLen = 8'd5; rxLen = 8'd5; fillByte = 8'h99;
    startReq = 1'b1;
    @(posedge clk); #1 startReq = 1'b0;
    while (nEnd + nStop == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    armed = 1'b0;
    check(nStart == 1, "R9 second start ignored", nStart, 1);
    check(sIdx == 2, "R10 length kept", sIdx, 2);
    check(sGot[1] == mem[8'h11], "R10 base kept", sGot[1], mem[8'h11]);
    check(nRd == 2 && nWr == 2, "R10 counts kept", nRd * 16 + nWr, 34);
  endtask

  task automatic t_stop_idle();
    prep(1'b0, 1'b0, 8'h10, 1, 8'h80, 1, 8'h00, 8);
    @(posedge clk); #1 stopReq = 1'b1;
    @(posedge clk); #1 stopReq = 1'b0;
    repeat (20) @(negedge clk);
    armed = 1'b0;
    check(nStop == 0 && nStart == 0 && nTx == 0 && nRx == 0, "R12 idle stop ignored",
          nStop + nStart + nTx + nRx, 0);
    check(nRd == 0 && nWr == 0, "R12 idle stop no access", nRd + nWr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    clear_counts();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_mode(1'b0, 1'b0, 3, 3, 0);
    t_mode(1'b0, 1'b1, 2, 2, 1);
    t_mode(1'b1, 1'b0, 2, 2, 2);
    t_mode(1'b1, 1'b1, 2, 2, 9);
    t_mode(1'b0, 1'b0, 1, 3, 10);
    t_mode(1'b1, 1'b1, 3, 1, 11);
    t_zero();
    t_stop_mid();
    t_stop_last();
    t_busy_start();
    t_stop_idle();
    check(!bothSeen, "R13 single memory access per cycle", bothSeen, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule